// File: doc/BRIEF.md
# Host/Device Mailbox Register File

This block is a small register file shared by two independent 8-bit Wishbone slave ports. One port faces the host side, reached through a parallel-port bridge. The other faces an on-chip processor. Each port has a 3-bit address and sees the same eight-byte map. It holds:

- a control byte, which carries a device reset request and a memory-ownership select;
- eight mailbox flag bits, which the host sets and the device clears;
- a shared mailbox byte;
- a switch/LED byte;
- four seven-segment digit bytes.

The block drives the flag vector and a reset line to the device, the LED bus and a time-multiplexed four-digit seven-segment display. The display uses active-low segments, a decimal point and active-low anodes.

The two ports have different rights. The host alone may change the control byte. A flag bit is set by a host write of one and cleared by a device write of one. When both ports write the same byte in one cycle, the host value is kept.

The map, with offsets that both ports decode:

| Offset | Byte |
|--------|------|
| 0 | control |
| 1 | flags |
| 2 | mailbox |
| 3 | switches on read, LEDs on write |
| 4 to 7 | digits 0 to 3 |

Top module: `hostdev_mailbox`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, both acks are low and the flags, control and mailbox bytes are zero. `led` and all four digit bytes are 0xFF. `an` is 4'b1110, `seg` is 7'h7F and `dp` is 1.
- R2: A port raises its ack exactly one cycle after it samples CYC and STB high. The ack lasts one cycle. Read data is valid with the ack and is selected by that port's own address.
- R3: Offset 0 is the control byte. A host write stores data bits 7 and 6; bits 5 to 0 always read 0. A device write to offset 0 has no effect, and a device read returns the control byte.
- R4: `dev_rst` is high whenever `rst` is high or control bit 7 is 1. `mem_to_host` equals control bit 6, where 1 means the host owns memory.
- R5: Offset 1 holds the flags. A host write sets each flag bit where the data has a 1. A device write clears each flag bit where the data has a 1. `dev_flags` always shows the flag byte.
- R6: Offset 2 is a mailbox byte that both ports may read and write.
- R7: A read of offset 3 from either port returns `sw_in` as it stood at the request. A write of offset 3 from either port sets `led`, which changes one cycle after the write is sampled.
- R8: Offsets 4 to 7 hold digits 0 to 3, and both ports may read and write them.
- R9: Exactly one `an` bit is low at any time. Digit 0 is `an[0]`, the rightmost display. The enabled digit steps 0, 1, 2, 3, 0 and holds for 2^SCAN_BITS clocks. `seg[6:0]` shows digit bits 6 to 0, which light segments a to g (top, upper-right, lower-right, bottom, lower-left, upper-left, middle). `dp` shows digit bit 7. A segment is lit when its bit is 0.
- R10: When both ports write the same byte in one cycle, the host data is kept. For the flags, the two masks are applied together, and a bit that is both set and cleared ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_cyc | input | 1 | Host port cycle |
| h_stb | input | 1 | Host port strobe |
| h_we | input | 1 | Host port write enable |
| h_adr | input | 3 | Host port byte offset |
| h_wdat | input | 8 | Host port write data |
| h_ack | output | 1 | Host port acknowledge |
| h_rdat | output | 8 | Host port read data |
| d_cyc | input | 1 | Device port cycle |
| d_stb | input | 1 | Device port strobe |
| d_we | input | 1 | Device port write enable |
| d_adr | input | 3 | Device port byte offset |
| d_wdat | input | 8 | Device port write data |
| d_ack | output | 1 | Device port acknowledge |
| d_rdat | output | 8 | Device port read data |
| sw_in | input | 8 | Switch inputs |
| dev_flags | output | 8 | Mailbox flag vector to the device |
| dev_rst | output | 1 | Reset to the device |
| mem_to_host | output | 1 | Memory ownership select (1 means host) |
| led | output | 8 | LED outputs |
| seg | output | 7 | Active-low segments a to g |
| dp | output | 1 | Active-low decimal point |
| an | output | 4 | Active-low digit enables |

## Verification
Acks, read data, `led`, `dev_flags`, `dev_rst` and `mem_to_host` all become valid one clock after the edge that samples the request. The bench therefore drives requests on the falling edge. It checks every result on the next falling edge, half a cycle after that sampling edge.

The display outputs sit one register behind the refresh counter. The scan checks therefore look only at the relation between the anode and the segments on each falling edge, and at the length and order of each anode run. They never rely on an absolute phase, except for the fixed state on the first cycle after reset.

Collision cases drive both ports in the same cycle. They then read the byte back one request later.

// File: rtl/hdm_pkg.sv
package hdm_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam int NUM_DIG = 4;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_FLAG = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_MBOX = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_IO   = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_DIG  = 3'd4;

  localparam int CTRL_RST_BIT = 7;
  localparam int CTRL_MEM_BIT = 6;

  localparam int PORT_HOST = 0;
  localparam int PORT_DEV  = 1;
endpackage

// File: rtl/hdm_wb_port.sv
module hdm_wb_port #(
  parameter int AW = 3,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cyc,
  input  logic          stb,
  input  logic          we,
  input  logic [DW-1:0] rd_word,
  output logic          ack,
  output logic [DW-1:0] rdat,
  output logic          wr_en
);
  logic          ack_q;
  logic [DW-1:0] rdat_q;
  logic          req;

  // A request is taken once; the acked cycle does not start a new one.
  assign req   = cyc && stb && !ack_q;
  assign wr_en = req && we;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q  <= 1'b0;
      rdat_q <= '0;
    end else begin
      ack_q <= req;
      if (req) rdat_q <= rd_word;
    end
  end

  assign ack  = ack_q;
  assign rdat = rdat_q;
endmodule

// File: rtl/hdm_regfile.sv
module hdm_regfile
  import hdm_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 3,
  parameter int ND = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            h_wr,
  input  logic [AW-1:0]   h_adr,
  input  logic [DW-1:0]   h_wd,
  input  logic            d_wr,
  input  logic [AW-1:0]   d_adr,
  input  logic [DW-1:0]   d_wd,
  input  logic [DW-1:0]   sw_in,
  output logic [DW-1:0]   h_rword,
  output logic [DW-1:0]   d_rword,
  output logic [DW-1:0]   ctrl,
  output logic [DW-1:0]   flags,
  output logic [DW-1:0]   led,
  output logic [ND*DW-1:0] digits
);
  localparam logic [DW-1:0] CTRL_MASK = DW'((1 << CTRL_RST_BIT) | (1 << CTRL_MEM_BIT));

  logic [DW-1:0] ctrl_q, flag_q, mbox_q, led_q;
  logic [DW-1:0] dig_q [ND];
  logic [DW-1:0] set_m, clr_m;

  assign set_m = (h_wr && h_adr == OFS_FLAG) ? h_wd : '0;
  assign clr_m = (d_wr && d_adr == OFS_FLAG) ? d_wd : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      flag_q <= '0;
      mbox_q <= '0;
      led_q  <= '1;
    end else begin
      if (h_wr && h_adr == OFS_CTRL) ctrl_q <= h_wd & CTRL_MASK;
      flag_q <= (flag_q & ~clr_m) | set_m;
      if (h_wr && h_adr == OFS_MBOX)      mbox_q <= h_wd;
      else if (d_wr && d_adr == OFS_MBOX) mbox_q <= d_wd;
      if (h_wr && h_adr == OFS_IO)        led_q <= h_wd;
      else if (d_wr && d_adr == OFS_IO)   led_q <= d_wd;
    end
  end

  for (genvar g = 0; g < ND; g++) begin : g_dig
    localparam logic [AW-1:0] OFS = AW'(OFS_DIG + g);
    always_ff @(posedge clk) begin
      if (rst)                         dig_q[g] <= '1;
      else if (h_wr && h_adr == OFS)   dig_q[g] <= h_wd;
      else if (d_wr && d_adr == OFS)   dig_q[g] <= d_wd;
    end
    assign digits[g*DW +: DW] = dig_q[g];
  end

  function automatic logic [DW-1:0] pick(input logic [AW-1:0] a);
    logic [DW-1:0] r;
    r = '1;
    case (a)
      OFS_CTRL: r = ctrl_q;
      OFS_FLAG: r = flag_q;
      OFS_MBOX: r = mbox_q;
      OFS_IO:   r = sw_in;
      default: begin
        for (int i = 0; i < ND; i++)
          if (a == AW'(OFS_DIG + i)) r = dig_q[i];
      end
    endcase
    return r;
  endfunction

  assign h_rword = pick(h_adr);
  assign d_rword = pick(d_adr);
  assign ctrl  = ctrl_q;
  assign flags = flag_q;
  assign led   = led_q;
endmodule

// File: rtl/hdm_scan.sv
module hdm_scan #(
  parameter int DW = 8,
  parameter int ND = 4,
  parameter int SCAN_BITS = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [ND*DW-1:0] digits,
  output logic [6:0]      seg,
  output logic            dp,
  output logic [ND-1:0]   an
);
  localparam int SELW = (ND > 1) ? $clog2(ND) : 1;
  localparam int CW   = SCAN_BITS + SELW;

  logic [CW-1:0]   cnt_q;
  logic [SELW-1:0] sel;
  logic [DW-1:0]   cur;
  logic [6:0]      seg_q;
  logic            dp_q;
  logic [ND-1:0]   an_q;

  assign sel = cnt_q[CW-1 -: SELW];
  assign cur = digits[sel*DW +: DW];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      seg_q <= '1;
      dp_q  <= 1'b1;
      an_q  <= ND'(~ND'(1));
    end else begin
      if (ND > 1 && int'(sel) == ND - 1 && &cnt_q[SCAN_BITS-1:0])
        cnt_q <= '0;
      else
        cnt_q <= cnt_q + 1'b1;
      seg_q <= cur[6:0];
      dp_q  <= cur[7];
      an_q  <= ~(ND'(1) << sel);
    end
  end

  assign seg = seg_q;
  assign dp  = dp_q;
  assign an  = an_q;
endmodule

// File: rtl/hostdev_mailbox.sv
module hostdev_mailbox
  import hdm_pkg::*;
#(
  parameter int SCAN_BITS = 12
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        h_cyc,
  input  logic        h_stb,
  input  logic        h_we,
  input  logic [2:0]  h_adr,
  input  logic [7:0]  h_wdat,
  output logic        h_ack,
  output logic [7:0]  h_rdat,
  input  logic        d_cyc,
  input  logic        d_stb,
  input  logic        d_we,
  input  logic [2:0]  d_adr,
  input  logic [7:0]  d_wdat,
  output logic        d_ack,
  output logic [7:0]  d_rdat,
  input  logic [7:0]  sw_in,
  output logic [7:0]  dev_flags,
  output logic        dev_rst,
  output logic        mem_to_host,
  output logic [7:0]  led,
  output logic [6:0]  seg,
  output logic        dp,
  output logic [3:0]  an
);
  localparam int NP = 2;

  logic [NP-1:0]        p_cyc, p_stb, p_we, p_ack, p_wr;
  logic [DATA_W-1:0]    p_rword [NP];
  logic [DATA_W-1:0]    p_rdat  [NP];
  logic [DATA_W-1:0]    ctrl, flags;
  logic [NUM_DIG*DATA_W-1:0] digits;

  assign p_cyc = {d_cyc, h_cyc};
  assign p_stb = {d_stb, h_stb};
  assign p_we  = {d_we,  h_we};

  for (genvar p = 0; p < NP; p++) begin : g_port
    hdm_wb_port #(.AW(ADDR_W), .DW(DATA_W)) u_port (
      .clk(clk), .rst(rst),
      .cyc(p_cyc[p]), .stb(p_stb[p]), .we(p_we[p]),
      .rd_word(p_rword[p]),
      .ack(p_ack[p]), .rdat(p_rdat[p]), .wr_en(p_wr[p])
    );
  end

  hdm_regfile #(.DW(DATA_W), .AW(ADDR_W), .ND(NUM_DIG)) u_regs (
    .clk(clk), .rst(rst),
    .h_wr(p_wr[PORT_HOST]), .h_adr(h_adr), .h_wd(h_wdat),
    .d_wr(p_wr[PORT_DEV]),  .d_adr(d_adr), .d_wd(d_wdat),
    .sw_in(sw_in),
    .h_rword(p_rword[PORT_HOST]), .d_rword(p_rword[PORT_DEV]),
    .ctrl(ctrl), .flags(flags), .led(led), .digits(digits)
  );

  hdm_scan #(.DW(DATA_W), .ND(NUM_DIG), .SCAN_BITS(SCAN_BITS)) u_scan (
    .clk(clk), .rst(rst), .digits(digits),
    .seg(seg), .dp(dp), .an(an)
  );

  assign h_ack  = p_ack[PORT_HOST];
  assign d_ack  = p_ack[PORT_DEV];
  assign h_rdat = p_rdat[PORT_HOST];
  assign d_rdat = p_rdat[PORT_DEV];
  assign dev_flags   = flags;
  assign dev_rst     = rst | ctrl[CTRL_RST_BIT];
  assign mem_to_host = ctrl[CTRL_MEM_BIT];
endmodule

// File: rtl/hostdev_mailbox_chk.sv
module hostdev_mailbox_chk (
  input logic       clk,
  input logic       rst,
  input logic       h_cyc,
  input logic       h_stb,
  input logic       h_we,
  input logic [2:0] h_adr,
  input logic [7:0] h_wdat,
  input logic       h_ack,
  input logic       d_cyc,
  input logic       d_stb,
  input logic       d_we,
  input logic [2:0] d_adr,
  input logic [7:0] d_wdat,
  input logic       d_ack,
  input logic [7:0] dev_flags,
  input logic       dev_rst,
  input logic       mem_to_host,
  input logic [3:0] an
);
  logic hw, dw;
  assign hw = h_cyc && h_stb && h_we && !h_ack;
  assign dw = d_cyc && d_stb && d_we && !d_ack;

  assert_h_ack_req_R2: assert property (@(posedge clk) disable iff (rst)
    h_ack |-> $past(h_cyc && h_stb));
  assert_d_ack_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    d_ack |=> !d_ack);
  assert_ctrl_dev_ignored_R3: assert property (@(posedge clk) disable iff (rst)
    (dw && d_adr == 3'd0 && !(hw && h_adr == 3'd0)) |=> ($stable(dev_rst) && $stable(mem_to_host)));
  assert_dev_rst_follow_R4: assert property (@(posedge clk) disable iff (rst)
    (hw && h_adr == 3'd0) |=> (dev_rst == $past(h_wdat[7]) && mem_to_host == $past(h_wdat[6])));
  assert_flag_set_R5: assert property (@(posedge clk) disable iff (rst)
    (hw && h_adr == 3'd1) |=> ((dev_flags & $past(h_wdat)) == $past(h_wdat)));
  assert_flag_clr_R5: assert property (@(posedge clk) disable iff (rst)
    (dw && d_adr == 3'd1 && !(hw && h_adr == 3'd1)) |=> ((dev_flags & $past(d_wdat)) == 8'h00));
  assert_an_onehot_R9: assert property (@(posedge clk) disable iff (rst)
    $countones(~an) == 1);
endmodule

bind hostdev_mailbox hostdev_mailbox_chk u_chk (.*);

// File: tb/hostdev_mailbox_tb.sv
module hostdev_mailbox_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SB = 3;
  localparam int RUN = 1 << SB;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic h_cyc = 0, h_stb = 0, h_we = 0, d_cyc = 0, d_stb = 0, d_we = 0;
  logic [2:0] h_adr = 0, d_adr = 0;
  logic [7:0] h_wdat = 0, d_wdat = 0, sw_in = 8'h00;
  logic h_ack, d_ack, dev_rst, mem_to_host, dp;
  logic [7:0] h_rdat, d_rdat, dev_flags, led;
  logic [6:0] seg;
  logic [3:0] an;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hostdev_mailbox #(.SCAN_BITS(SB)) u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // One bus request on one port (0 host, 1 device); returns read data.
  task automatic bus_op(input bit port, input bit we, input logic [2:0] adr,
                        input logic [7:0] wd, output logic [7:0] rd);
    @(negedge clk);
    if (!port) begin h_cyc = 1; h_stb = 1; h_we = we; h_adr = adr; h_wdat = wd; end
    else       begin d_cyc = 1; d_stb = 1; d_we = we; d_adr = adr; d_wdat = wd; end
    @(negedge clk);
    rd = port ? d_rdat : h_rdat;
    if (!port) begin h_cyc = 0; h_stb = 0; h_we = 0; end
    else       begin d_cyc = 0; d_stb = 0; d_we = 0; end
  endtask

  task automatic both_write(input logic [2:0] adr, input logic [7:0] hv, input logic [7:0] dv);
    @(negedge clk);
    h_cyc = 1; h_stb = 1; h_we = 1; h_adr = adr; h_wdat = hv;
    d_cyc = 1; d_stb = 1; d_we = 1; d_adr = adr; d_wdat = dv;
    @(negedge clk);
    h_cyc = 0; h_stb = 0; h_we = 0; d_cyc = 0; d_stb = 0; d_we = 0;
  endtask

  // {req[4], port, we, adr[3], data[8]}
  localparam int NV = 19;
  localparam logic [16:0] VEC [NV] = '{
    {4'd6,  1'b0, 1'b1, 3'd2, 8'h5A},   // R6 host write mailbox
    {4'd6,  1'b1, 1'b0, 3'd2, 8'h5A},   // R6 device read
    {4'd6,  1'b1, 1'b1, 3'd2, 8'hC3},   // R6 device write
    {4'd6,  1'b0, 1'b0, 3'd2, 8'hC3},   // R6 host read
    {4'd5,  1'b0, 1'b1, 3'd1, 8'h81},   // R5 host sets
    {4'd5,  1'b1, 1'b0, 3'd1, 8'h81},
    {4'd5,  1'b0, 1'b1, 3'd1, 8'h06},
    {4'd5,  1'b0, 1'b0, 3'd1, 8'h87},
    {4'd5,  1'b1, 1'b1, 3'd1, 8'h03},   // R5 device clears
    {4'd5,  1'b1, 1'b0, 3'd1, 8'h84},
    {4'd3,  1'b0, 1'b1, 3'd0, 8'hC0},   // R3 host writes control
    {4'd3,  1'b1, 1'b1, 3'd0, 8'h00},   // R3 device write ignored
    {4'd3,  1'b1, 1'b0, 3'd0, 8'hC0},
    {4'd3,  1'b0, 1'b1, 3'd0, 8'h3F},   // R3 low bits unused
    {4'd3,  1'b0, 1'b0, 3'd0, 8'h00},
    {4'd8,  1'b1, 1'b1, 3'd4, 8'hA4},   // R8 digits
    {4'd8,  1'b0, 1'b0, 3'd4, 8'hA4},
    {4'd8,  1'b0, 1'b1, 3'd7, 8'h12},
    {4'd8,  1'b1, 1'b0, 3'd7, 8'h12}
  };

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [7:0] rd;
    int prev_an, run_len, nxt;
    bit seen [4];
    bit bad_pair, bad_order, bad_len;

    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R4 dev_rst during reset", dev_rst, 1);
    rst = 0;
    @(negedge clk);
    chk("R1 host ack", h_ack, 0);
    chk("R1 device ack", d_ack, 0);
    chk("R1 led", led, 8'hFF);
    chk("R1 flags", dev_flags, 8'h00);
    chk("R1 anodes", an, 4'b1110);
    chk("R1 seg/dp", {dp, seg}, 8'hFF);
    chk("R4 dev_rst after reset", dev_rst, 0);
    chk("R4 mem_to_host reset", mem_to_host, 0);
    bus_op(0, 0, 3'd5, 0, rd); chk("R1 digit1 reset", rd, 8'hFF);
    bus_op(1, 0, 3'd2, 0, rd); chk("R1 mailbox reset", rd, 8'h00);

    // R2 ack timing
    @(negedge clk);
    h_cyc = 1; h_stb = 1; h_we = 0; h_adr = 3'd2;
    chk("R2 ack not same cycle", h_ack, 0);
    @(negedge clk);
    chk("R2 ack one cycle later", h_ack, 1);
    h_cyc = 0; h_stb = 0;
    @(negedge clk);
    chk("R2 ack one cycle only", h_ack, 0);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      bus_op(VEC[i][12], VEC[i][11], VEC[i][10:8], VEC[i][7:0], rd);
      if (!VEC[i][11]) begin
        checks++;
        if (rd !== VEC[i][7:0]) begin
          errors++;
          $display("FAIL R%0d row %0d: actual %0h expected %0h", VEC[i][16:13], i, rd, VEC[i][7:0]);
        end
      end
    end
    chk("R5 dev_flags output", dev_flags, 8'h84);

    // R2 own-address read data with both ports busy
    @(negedge clk);
    h_cyc = 1; h_stb = 1; h_we = 0; h_adr = 3'd1;
    d_cyc = 1; d_stb = 1; d_we = 0; d_adr = 3'd4;
    @(negedge clk);
    chk("R2 host own address", h_rdat, 8'h84);
    chk("R2 device own address", d_rdat, 8'hA4);
    h_cyc = 0; h_stb = 0; d_cyc = 0; d_stb = 0;

    // R4 control outputs
    bus_op(0, 1, 3'd0, 8'h80, rd);
    chk("R4 dev_rst set", dev_rst, 1);
    chk("R4 mem_to_host clear", mem_to_host, 0);
    bus_op(1, 1, 3'd0, 8'h40, rd);
    chk("R3 device write no effect on dev_rst", dev_rst, 1);
    chk("R3 device write no effect on mem", mem_to_host, 0);
    bus_op(0, 1, 3'd0, 8'h40, rd);
    chk("R4 dev_rst clear", dev_rst, 0);
    chk("R4 mem_to_host set", mem_to_host, 1);

    // R7 switches and LEDs
    bus_op(0, 1, 3'd3, 8'h0F, rd);
    chk("R7 host led write", led, 8'h0F);
    bus_op(1, 1, 3'd3, 8'hF0, rd);
    chk("R7 device led write", led, 8'hF0);
    sw_in = 8'hA5;
    bus_op(0, 0, 3'd3, 0, rd); chk("R7 host switch read", rd, 8'hA5);
    sw_in = 8'h3C;
    bus_op(1, 0, 3'd3, 0, rd); chk("R7 device switch read", rd, 8'h3C);
    chk("R7 led held by read", led, 8'hF0);

    // R10 collisions
    both_write(3'd2, 8'h11, 8'h22);
    bus_op(1, 0, 3'd2, 0, rd); chk("R10 host wins mailbox", rd, 8'h11);
    both_write(3'd3, 8'h55, 8'hAA);
    chk("R10 host wins led", led, 8'h55);
    both_write(3'd1, 8'h01, 8'h05);
    chk("R10 flags set priority", dev_flags, 8'h81);

    // R9 scan: digits 0..3
    bus_op(0, 1, 3'd4, 8'hC0, rd);
    bus_op(1, 1, 3'd5, 8'hF9, rd);
    bus_op(0, 1, 3'd6, 8'hA4, rd);
    bus_op(1, 1, 3'd7, 8'h30, rd);
    prev_an = -1; run_len = 0; bad_pair = 0; bad_order = 0; bad_len = 0;
    for (int k = 0; k < 4; k++) seen[k] = 0;
    for (int c = 0; c < RUN * 4 * 3; c++) begin
      logic [7:0] ex;
      @(negedge clk);
      nxt = -1;
      for (int k = 0; k < 4; k++) if (an == ~(4'b1 << k)) nxt = k;
      if (nxt < 0) bad_pair = 1;
      else begin
        seen[nxt] = 1;
        case (nxt)
          0: ex = 8'hC0; 1: ex = 8'hF9; 2: ex = 8'hA4; default: ex = 8'h30;
        endcase
        if ({dp, seg} !== ex) bad_pair = 1;
        if (nxt != prev_an) begin
          if (prev_an >= 0 && nxt != (prev_an + 1) % 4) bad_order = 1;
          if (prev_an >= 0 && run_len != RUN && c >= RUN * 4) bad_len = 1;
          run_len = 1;
          prev_an = nxt;
        end else run_len++;
      end
    end
    chk("R9 one anode with its digit pattern", bad_pair, 0);
    chk("R9 rotation order", bad_order, 0);
    chk("R9 dwell length", bad_len, 0);
    chk("R9 all digits shown", {seen[3], seen[2], seen[1], seen[0]}, 4'hF);

    // R1 reset again
    @(negedge clk); rst = 1;
    @(negedge clk); @(negedge clk);
    chk("R1 led after reset", led, 8'hFF);
    chk("R1 flags after reset", dev_flags, 8'h00);
    chk("R1 mem after reset", mem_to_host, 0);
    rst = 0;
    @(negedge clk);

    done = 1;
    finish_run();
  end
endmodule